// File: doc/BRIEF.md
# Register-to-Stream Operand Redirector

This block sits between the operand ports of a single-issue core and its physical register file. While a global streaming switch is on, a few chosen architectural registers stop behaving as storage and act as stream ports instead. A read of one of these registers takes the next element from an input stream. A write sends the value out on an output stream. The core therefore gets implicit loads and stores, and a loop body needs no explicit memory instructions. All other registers, and all registers while the switch is off, reach the register file untouched.

Two stream lanes are provided. Lane 0 serves integer register x5 and floating-point register f0. Lane 1 serves integer register x6 and floating-point register f1. Each lane has an input stream and an output stream, and each stream uses a valid/ready handshake. The switch is bit 0 of a control register at CSR address 0x7C0. When a stream cannot complete its handshake, the block raises a stall toward the pipeline. The pipeline then holds the instruction's requests stable until the stall drops.

Top module: `regstream_redirect`

## Requirements
- R1: After reset, streaming is off, a CSR read at 0x7C0 returns 0, and no stream ready, stream valid or stall is raised.
- R2: A CSR write to 0x7C0 loads bit 0 of the write data into the enable. A CSR read at 0x7C0 returns the enable in bit 0 and zeros in bits 31..1. A write to any other CSR address leaves the enable unchanged, and a read at any other address returns 0.
- R3: While enabled, a read of x5 or f0 on any source slot (slot 0 = rs1, 1 = rs2, 2 = rs3) pops lane 0, and a read of x6 or f1 pops lane 1. The popped element appears on that slot's read data, and the slot's register-file read enable stays low.
- R4: While enabled, a write to x5/f0 (lane 0) or x6/f1 (lane 1) presents the write data on that lane's output stream with valid high. Exactly one element is transferred, and the register-file write enable stays low.
- R5: Reads and writes of any other register go to the register file. The read data comes from the register file, and no stream signal is raised.
- R6: While disabled, accesses to x5, x6, f0 and f1 also go to the register file, and no stream ready or valid is raised.
- R7: A stream read that finds valid low raises stall. Stall stays high until the element arrives, and the data is delivered in the cycle the handshake completes.
- R8: A stream write that finds ready low raises stall. Stall stays high until ready is seen, and the element is transferred once.
- R9: When several source slots name registers of the same lane, one element is popped per cycle in slot order rs1, rs2, rs3. Each earlier slot keeps its element, and stall stays high until the last slot is served. Slots on different lanes are served in the same cycle.
- R10: A CSR write to the enable takes effect from the next cycle. An access in the same cycle as the write uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 3 | Source slot read requests (bit i = slot i) |
| rd_fp | input | 3 | Slot targets the floating-point file |
| rd_addr | input | 15 | Register index, 5 bits per slot |
| rd_data | output | 3*DW | Operand data, DW bits per slot |
| wr_en | input | 1 | Destination write request |
| wr_fp | input | 1 | Destination is in the floating-point file |
| wr_addr | input | 5 | Destination register index |
| wr_data | input | DW | Destination write data |
| rf_rd_en | output | 3 | Register-file read enables |
| rf_rd_fp | output | 3 | Register-file file select per slot |
| rf_rd_addr | output | 15 | Register-file read indices |
| rf_rd_data | input | 3*DW | Register-file read data |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_fp | output | 1 | Register-file write file select |
| rf_wr_addr | output | 5 | Register-file write index |
| rf_wr_data | output | DW | Register-file write data |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data |
| sin_valid | input | 2 | Input stream valid per lane |
| sin_ready | output | 2 | Input stream ready per lane |
| sin_data | input | 2*DW | Input stream data per lane |
| sout_valid | output | 2 | Output stream valid per lane |
| sout_ready | input | 2 | Output stream ready per lane |
| sout_data | output | 2*DW | Output stream data per lane |
| stall | output | 1 | Pipeline hold request |

## Verification
Two pairs of functions can fall in the same cycle. First, a CSR write that changes the enable can arrive together with an access to a stream register. The bench turns streaming on, and later off, in the very cycle it reads x5 or x6. It then judges from rf_rd_en and sin_ready that the old setting steered that access and the new one steers the next. Second, several slots can want the same lane at once. The bench issues rs1/rs2/rs3 all on lane 0 with a fresh element each cycle, and checks the stall pattern and that each slot holds its own element in order. Stream pushes are collected by a scoreboard monitor and compared against the values the driver queued.

// File: rtl/regstream_redirect.sv
module regstream_redirect #(
  parameter int          DW       = 64,
  parameter logic [11:0] CSR_ADDR = 12'h7C0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      rd_en,
  input  logic [2:0]      rd_fp,
  input  logic [14:0]     rd_addr,
  output logic [3*DW-1:0] rd_data,
  input  logic            wr_en,
  input  logic            wr_fp,
  input  logic [4:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [2:0]      rf_rd_en,
  output logic [2:0]      rf_rd_fp,
  output logic [14:0]     rf_rd_addr,
  input  logic [3*DW-1:0] rf_rd_data,
  output logic            rf_wr_en,
  output logic            rf_wr_fp,
  output logic [4:0]      rf_wr_addr,
  output logic [DW-1:0]   rf_wr_data,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [31:0]     csr_wdata,
  output logic [31:0]     csr_rdata,
  input  logic [1:0]      sin_valid,
  output logic [1:0]      sin_ready,
  input  logic [2*DW-1:0] sin_data,
  output logic [1:0]      sout_valid,
  input  logic [1:0]      sout_ready,
  output logic [2*DW-1:0] sout_data,
  output logic            stall
);
  localparam int NSLOT = 3;

  logic             en;
  logic [NSLOT-1:0] strm, ln, need, sel, fire, done;
  logic [DW-1:0]    held [NSLOT];
  logic             wstrm, wln, wneed, wfire, wdone;

  function automatic logic mapped(input logic fp, input logic [4:0] a);
    return fp ? (a == 5'd0 || a == 5'd1) : (a == 5'd5 || a == 5'd6);
  endfunction

  function automatic logic lane_of(input logic fp, input logic [4:0] a);
    return fp ? a[0] : (a == 5'd6);
  endfunction

  always_comb begin
    sin_ready = '0;
    for (int i = 0; i < NSLOT; i++) begin
      strm[i] = en && rd_en[i] && mapped(rd_fp[i], rd_addr[i*5 +: 5]);
      ln[i]   = lane_of(rd_fp[i], rd_addr[i*5 +: 5]);
    end
    need = strm & ~done;
    for (int i = 0; i < NSLOT; i++) begin
      sel[i] = need[i];
      for (int j = 0; j < i; j++)
        if (need[j] && ln[j] == ln[i]) sel[i] = 1'b0;
      fire[i] = sel[i] && sin_valid[ln[i]];
      if (sel[i]) sin_ready[ln[i]] = 1'b1;
    end
    for (int i = 0; i < NSLOT; i++) begin
      if (!strm[i])     rd_data[i*DW +: DW] = rf_rd_data[i*DW +: DW];
      else if (fire[i]) rd_data[i*DW +: DW] = ln[i] ? sin_data[2*DW-1:DW] : sin_data[DW-1:0];
      else              rd_data[i*DW +: DW] = held[i];
    end
  end

  assign wstrm      = en && wr_en && mapped(wr_fp, wr_addr);
  assign wln        = lane_of(wr_fp, wr_addr);
  assign wneed      = wstrm && !wdone;
  assign wfire      = wneed && sout_ready[wln];
  assign sout_valid = wneed ? (wln ? 2'b10 : 2'b01) : 2'b00;
  assign sout_data  = {wr_data, wr_data};

  assign rf_rd_en   = rd_en & ~strm;
  assign rf_rd_fp   = rd_fp;
  assign rf_rd_addr = rd_addr;
  assign rf_wr_en   = wr_en && !wstrm;
  assign rf_wr_fp   = wr_fp;
  assign rf_wr_addr = wr_addr;
  assign rf_wr_data = wr_data;

  assign csr_rdata  = (csr_addr == CSR_ADDR) ? {31'b0, en} : 32'b0;
  assign stall      = |(need & ~fire) || (wneed && !wfire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      done  <= '0;
      wdone <= 1'b0;
      for (int i = 0; i < NSLOT; i++) held[i] <= '0;
    end else begin
      if (csr_we && csr_addr == CSR_ADDR) en <= csr_wdata[0];
      done  <= stall ? (done | fire) : '0;
      wdone <= stall ? (wdone | wfire) : 1'b0;
      for (int i = 0; i < NSLOT; i++)
        if (fire[i]) held[i] <= ln[i] ? sin_data[2*DW-1:DW] : sin_data[DW-1:0];
    end
  end

  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (sin_ready == 2'b00 && sout_valid == 2'b00 && !stall));
  // R7
  stall_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(sin_ready & ~sin_valid) |-> stall);
  // R8
  stall_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(sout_valid & ~sout_ready) |-> stall);
  // R4
  push_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |sout_valid |-> !rf_wr_en);
  // R2
  csr_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[31:1] == 31'b0);
  // R10
  csr_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == CSR_ADDR) |=> (en == $past(csr_wdata[0])));
endmodule

// File: tb/regstream_redirect_tb.sv
module regstream_redirect_tb;
  localparam int DW = 64;
  logic            clk = 1'b0, rst_n = 1'b0;
  logic [2:0]      rd_en, rd_fp, rf_rd_en, rf_rd_fp;
  logic [14:0]     rd_addr, rf_rd_addr;
  logic [3*DW-1:0] rd_data, rf_rd_data;
  logic            wr_en, wr_fp, rf_wr_en, rf_wr_fp, csr_we, stall;
  logic [4:0]      wr_addr, rf_wr_addr;
  logic [DW-1:0]   wr_data, rf_wr_data;
  logic [11:0]     csr_addr;
  logic [31:0]     csr_wdata, csr_rdata;
  logic [1:0]      sin_valid, sin_ready, sout_valid, sout_ready;
  logic [2*DW-1:0] sin_data, sout_data;
  int nchk = 0, nfail = 0;
  logic [DW:0] pushq [$];

  localparam logic [DW-1:0] RF0 = 64'hAAAA_0000_0000_0001;
  localparam logic [DW-1:0] RF1 = 64'hBBBB_0000_0000_0002;
  localparam logic [DW-1:0] RF2 = 64'hCCCC_0000_0000_0003;
  assign rf_rd_data = {RF2, RF1, RF0};

  always #5 clk = ~clk;

  regstream_redirect #(.DW(DW)) u_dut (.*);

  task automatic chk(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic clr();
    rd_en = '0; rd_fp = '0; rd_addr = '0; wr_en = 0; wr_fp = 0; wr_addr = '0; wr_data = '0;
    csr_we = 0; csr_addr = 12'h7C0; csr_wdata = '0;
    sin_valid = '0; sin_data = '0; sout_ready = '0;
  endtask

  task automatic slot(input int i, input logic fp, input logic [4:0] a);
    rd_en[i] = 1'b1; rd_fp[i] = fp; rd_addr[i*5 +: 5] = a;
  endtask

  function automatic logic [DW-1:0] rdv(input int i);
    return rd_data[i*DW +: DW];
  endfunction

  task automatic expect_push(input logic lane, input logic [DW-1:0] d);
    pushq.push_back({lane, d});
  endtask

  always @(negedge clk) begin
    #4;
    for (int l = 0; l < 2; l++)
      if (sout_valid[l] && sout_ready[l]) begin
        if (pushq.size() == 0) chk("R4 unexpected push", {63'b0, l[0]}, '1);
        else begin
          logic [DW:0] e;
          e = pushq.pop_front();
          chk("R4 push lane", {63'b0, l[0]}, {63'b0, e[DW]});
          chk("R4 push data", sout_data[l*DW +: DW], e[DW-1:0]);
        end
      end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    @(negedge clk); clr(); #3;
    chk("R1 csr", csr_rdata, 0);
    chk("R1 ready", sin_ready, 0);
    chk("R1 stall", stall, 0);

    @(negedge clk); clr(); slot(0, 0, 5); wr_en = 1; wr_addr = 6; sin_valid = 2'b11; sout_ready = 2'b11; #3;
    chk("R6 rf rd", rf_rd_en, 3'b001);
    chk("R6 data", rdv(0), RF0);
    chk("R6 ready", sin_ready, 0);
    chk("R6 rf wr", rf_wr_en, 1);
    chk("R6 valid", sout_valid, 0);

    @(negedge clk); clr(); csr_we = 1; csr_addr = 12'h7C1; csr_wdata = 1;
    @(negedge clk); clr(); #3;
    chk("R2 other addr", csr_rdata, 0);
    csr_addr = 12'h7C1; #1;
    chk("R2 other read", csr_rdata, 0);

    @(negedge clk); clr(); csr_we = 1; csr_wdata = 32'hFFFF_FFFF; slot(0, 0, 5); sin_valid = 2'b11; #3;
    chk("R10 old off", rf_rd_en, 3'b001);
    chk("R10 no ready", sin_ready, 0);
    @(negedge clk); clr(); #3;
    chk("R2 enable read", csr_rdata, 1);

    @(negedge clk); clr(); slot(0, 0, 5); sin_valid = 2'b01; sin_data[63:0] = 64'hA1; #3;
    chk("R3 x5 data", rdv(0), 64'hA1);
    chk("R3 ready", sin_ready, 2'b01);
    chk("R3 rf off", rf_rd_en, 0);
    chk("R3 stall", stall, 0);
    @(negedge clk); clr(); slot(1, 1, 1); sin_valid = 2'b10; sin_data[127:64] = 64'hB2; #3;
    chk("R3 f1 data", rdv(1), 64'hB2);
    chk("R3 f1 ready", sin_ready, 2'b10);

    @(negedge clk); clr(); slot(0, 0, 7); slot(1, 1, 2); sin_valid = 2'b11; #3;
    chk("R5 rf rd", rf_rd_en, 3'b011);
    chk("R5 data0", rdv(0), RF0);
    chk("R5 data1", rdv(1), RF1);
    chk("R5 ready", sin_ready, 0);

    @(negedge clk); clr(); wr_en = 1; wr_addr = 6; wr_data = 64'hC3; sout_ready = 2'b10;
    expect_push(1'b1, 64'hC3); #3;
    chk("R4 valid", sout_valid, 2'b10);
    chk("R4 rf wr", rf_wr_en, 0);
    chk("R4 stall", stall, 0);
    @(negedge clk); clr(); wr_en = 1; wr_addr = 7; sout_ready = 2'b11; #3;
    chk("R5 rf wr", rf_wr_en, 1);
    chk("R5 no valid", sout_valid, 0);

    @(negedge clk); clr(); slot(0, 0, 5); #3;
    chk("R7 stall", stall, 1);
    chk("R7 ready", sin_ready, 2'b01);
    @(negedge clk); #3;
    chk("R7 stall held", stall, 1);
    @(negedge clk); sin_valid = 2'b01; sin_data[63:0] = 64'hD4; #3;
    chk("R7 release", stall, 0);
    chk("R7 data", rdv(0), 64'hD4);

    @(negedge clk); clr(); wr_en = 1; wr_fp = 1; wr_addr = 0; wr_data = 64'hE5; #3;
    chk("R8 stall", stall, 1);
    chk("R8 valid", sout_valid, 2'b01);
    @(negedge clk); sout_ready = 2'b01; expect_push(1'b0, 64'hE5); #3;
    chk("R8 release", stall, 0);

    @(negedge clk); clr(); slot(0, 0, 5); slot(1, 1, 0); slot(2, 0, 5);
    sin_valid = 2'b01; sin_data[63:0] = 64'h11; #3;
    chk("R9 stall 1", stall, 1);
    chk("R9 rs1", rdv(0), 64'h11);
    @(negedge clk); sin_data[63:0] = 64'h22; #3;
    chk("R9 stall 2", stall, 1);
    chk("R9 rs1 held", rdv(0), 64'h11);
    chk("R9 rs2", rdv(1), 64'h22);
    @(negedge clk); sin_data[63:0] = 64'h33; #3;
    chk("R9 stall 3", stall, 0);
    chk("R9 rs1 final", rdv(0), 64'h11);
    chk("R9 rs2 final", rdv(1), 64'h22);
    chk("R9 rs3 final", rdv(2), 64'h33);
    @(negedge clk); clr(); slot(0, 0, 5); slot(1, 0, 6); sin_valid = 2'b11;
    sin_data = {64'h66, 64'h55}; #3;
    chk("R9 two lanes stall", stall, 0);
    chk("R9 lane0", rdv(0), 64'h55);
    chk("R9 lane1", rdv(1), 64'h66);

    @(negedge clk); clr(); csr_we = 1; csr_wdata = 0; slot(0, 0, 6); sin_valid = 2'b10;
    sin_data[127:64] = 64'hF6; #3;
    chk("R10 old on", rdv(0), 64'hF6);
    chk("R10 old ready", sin_ready, 2'b10);
    @(negedge clk); csr_we = 0; #3;
    chk("R10 new off", rf_rd_en, 3'b001);
    chk("R10 new ready", sin_ready, 0);

    @(negedge clk); clr(); #3;
    chk("R4 queue drained", pushq.size(), 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule